// File: doc/BRIEF.md
# Serial Memory Status and Write Guard

This unit keeps the status byte and the write-enable latch of a 512-byte serial non-volatile memory. The serial front end decodes commands and raises one-cycle strobes: enable, disable, status write with a data byte, and array program with the first and last byte address of the range. For each status write or array program the unit returns a grant or a deny, and a granted request starts a self-timed busy period of a fixed number of system clocks.

Two retained protection bits pick one of four upper-address regions that array programs may not touch. The hardware protect input must be high, and the enable latch set, for any program to start. The latch clears itself on the clock where the busy period ends. While busy, only status reads are served, and they return all ones.

Top module: `nvm_status_guard`

## Requirements
- R1: When idle, status_o is bit0 ready flag (0), bit1 enable latch, bit2 protect-low bit, bit3 protect-high bit, bits 7..4 zero.
- R2: An asynchronous reset clears the enable latch and busy flag, while both protect bits keep their value (BP_INIT at start-up).
- R3: An enable strobe sets the latch and a disable strobe clears it. If both arrive together, the latch clears.
- R4: A status write or array program is granted only if wp_i is high and the enable latch is set; otherwise it is denied.
- R5: An array program is denied when the higher of its two addresses falls in the protected region: {bit3,bit2}=00 none, 01 0x180-0x1FF, 10 0x100-0x1FF, 11 0x000-0x1FF.
- R6: A granted status write copies data bits 3 and 2 into the protect-high and protect-low bits when its busy period ends, and it ignores the other data bits.
- R7: grant_o or deny_o pulses for one clock in the cycle after the request strobe. A grant raises busy_o in that same cycle, and busy_o stays high for BUSY_CYCLES clocks.
- R8: busy_o and the enable latch fall on the same clock.
- R9: While busy, status_o reads 0xFF, enable and disable strobes have no effect, and every request is denied.
- R10: A denied request leaves the enable latch unchanged and does not start busy.
- R11: If a request strobe is present in a cycle, enable and disable strobes in that cycle are ignored. An array program takes priority over a status write given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wp_i | input | 1 | Hardware write-protect input; high allows programs |
| set_wen_i | input | 1 | Enable strobe |
| clr_wen_i | input | 1 | Disable strobe |
| sr_wr_i | input | 1 | Status write request strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| prog_req_i | input | 1 | Array program request strobe |
| prog_first_i | input | ADDR_W | First byte address of the program |
| prog_last_i | input | ADDR_W | Last byte address of the program |
| status_o | output | 8 | Status byte for reads |
| grant_o | output | 1 | Request accepted pulse |
| deny_o | output | 1 | Request refused pulse |
| busy_o | output | 1 | Program cycle in progress |

## Verification
Array programs are tried at each protection level with ranges whose higher address lies just below and exactly on the region base. Reversed first/last order is included, which separates a compare of the maximum address from a compare of only one of the two addresses. Requests are sent with the protect input low and with the latch clear, which tells apart the two conditions for a grant. Strobes given during a busy period, and strobes given together with a request, show that the latch and the protect bits are left untouched. Reset is applied with the protect bits at a nonzero value, which shows they are retained.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  localparam int unsigned ST_RDY = 0;
  localparam int unsigned ST_WEN = 1;
  localparam int unsigned ST_BP0 = 2;
  localparam int unsigned ST_BP1 = 3;
  localparam int unsigned ST_W   = 8;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_lvl_e;

  function automatic logic [ST_W-1:0] pack_status(logic [1:0] bp, logic wen, logic busy);
    logic [ST_W-1:0] s;
    if (busy) begin
      s = '1;
    end else begin
      s = '0;
      s[ST_WEN] = wen;
      s[ST_BP0] = bp[0];
      s[ST_BP1] = bp[1];
    end
    return s;
  endfunction
endpackage

// File: rtl/nvm_prot_decode.sv
module nvm_prot_decode #(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [1:0]        lvl_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic              blocked_o
);
  import nvm_guard_pkg::*;

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] BASE_NONE = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W:0] BASE_QTR  = (ADDR_W+1)'(DEPTH - DEPTH/4);
  localparam logic [ADDR_W:0] BASE_HALF = (ADDR_W+1)'(DEPTH/2);
  localparam logic [ADDR_W:0] BASE_ALL  = '0;

  logic [ADDR_W:0]   base;
  logic [ADDR_W-1:0] top_addr;

  always_comb begin
    unique case (prot_lvl_e'(lvl_i))
      LVL_NONE:    base = BASE_NONE;
      LVL_QUARTER: base = BASE_QTR;
      LVL_HALF:    base = BASE_HALF;
      default:     base = BASE_ALL;
    endcase
  end

  // regions all end at the top address, so the highest target decides
  assign top_addr  = (first_i > last_i) ? first_i : last_i;
  assign blocked_o = {1'b0, top_addr} >= base;
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  assert_no_start_when_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  assert_busy_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q != '0) |=> busy_q);
  assert_done_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned BUSY_CYCLES = 1250000,
  parameter logic [1:0]  BP_INIT     = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              set_wen_i,
  input  logic              clr_wen_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              prog_req_i,
  input  logic [ADDR_W-1:0] prog_first_i,
  input  logic [ADDR_W-1:0] prog_last_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              deny_o,
  output logic              busy_o
);
  import nvm_guard_pkg::*;

  logic       wen_q, grant_q, deny_q;
  logic [1:0] bp_q = BP_INIT;   // retained: no reset
  logic [1:0] bp_pend_q;
  logic       pend_sts_q;
  logic       busy, done, blocked;
  logic       any_req, allowed, arr_ok, sts_ok, start;

  nvm_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
    .lvl_i     (bp_q),
    .first_i   (prog_first_i),
    .last_i    (prog_last_i),
    .blocked_o (blocked)
  );

  nvm_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  assign any_req = prog_req_i || sr_wr_i;
  assign allowed = wp_i && wen_q && !busy;
  assign arr_ok  = prog_req_i && allowed && !blocked;
  assign sts_ok  = sr_wr_i && !prog_req_i && allowed;
  assign start   = arr_ok || sts_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q      <= 1'b0;
      grant_q    <= 1'b0;
      deny_q     <= 1'b0;
      pend_sts_q <= 1'b0;
      bp_pend_q  <= 2'b00;
    end else begin
      grant_q <= start;
      deny_q  <= any_req && !start;
      if (done) begin
        wen_q      <= 1'b0;
        pend_sts_q <= 1'b0;
      end else if (!busy && !any_req) begin
        if (clr_wen_i)      wen_q <= 1'b0;
        else if (set_wen_i) wen_q <= 1'b1;
      end
      if (start) begin
        pend_sts_q <= sts_ok;
        bp_pend_q  <= sr_data_i[ST_BP1:ST_BP0];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (done && pend_sts_q) bp_q <= bp_pend_q;
  end

  assign status_o = pack_status(bp_q, wen_q, busy);
  assign grant_o  = grant_q;
  assign deny_o   = deny_q;
  assign busy_o   = busy;

  assert_grant_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_q |-> $past(wp_i) && $past(wen_q));
  assert_grant_deny_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_q && deny_q));
  assert_busy_from_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> grant_q);
  assert_wen_clears_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wen_q);
  assert_deny_no_effect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_q && !$past(busy) |-> !busy && (wen_q == $past(wen_q)));
  assert_bp_moves_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bp_q) |-> $past(busy) && !busy);
  assert_no_enable_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy) |-> !$rose(wen_q));
endmodule

// File: tb/nvm_status_guard_test.sv
module nvm_status_guard_test;
  localparam int unsigned AW = 9;
  localparam int unsigned BUSY = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wp_i = 1'b1;
  logic          set_wen_i = 1'b0, clr_wen_i = 1'b0, sr_wr_i = 1'b0, prog_req_i = 1'b0;
  logic [7:0]    sr_data_i = '0;
  logic [AW-1:0] prog_first_i = '0, prog_last_i = '0;
  logic [7:0]    status_o;
  logic          grant_o, deny_o, busy_o;
  int            checks = 0, errors = 0;

  nvm_status_guard #(.ADDR_W(AW), .BUSY_CYCLES(BUSY), .BP_INIT(2'b00)) uut (
    .clk_i, .rst_ni, .wp_i, .set_wen_i, .clr_wen_i, .sr_wr_i, .sr_data_i,
    .prog_req_i, .prog_first_i, .prog_last_i, .status_o, .grant_o, .deny_o, .busy_o
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [7:0] st(logic [1:0] bp, logic wen);
    return {4'b0000, bp, wen, 1'b0};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wait_idle();
    while (busy_o) step();
  endtask

  task automatic pulse_set();
    set_wen_i = 1'b1; step(); set_wen_i = 1'b0;
  endtask

  task automatic array_req(logic [AW-1:0] a, logic [AW-1:0] b);
    prog_first_i = a; prog_last_i = b; prog_req_i = 1'b1; step(); prog_req_i = 1'b0;
  endtask

  task automatic load_bp(logic [1:0] bp);
    pulse_set();
    sr_data_i = {4'hA, bp, 2'b11}; sr_wr_i = 1'b1; step(); sr_wr_i = 1'b0;
    chk("R6 load grant", grant_o, 1);
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R2 reset status", status_o, st(2'b00, 1'b0));
    chk("R2 reset busy", busy_o, 0);
    chk("R1 idle upper bits", status_o[7:4], 0);
  endtask

  task automatic t_latch();
    pulse_set();
    chk("R3 set", status_o, st(2'b00, 1'b1));
    clr_wen_i = 1'b1; step(); clr_wen_i = 1'b0;
    chk("R3 clear", status_o, st(2'b00, 1'b0));
    set_wen_i = 1'b1; clr_wen_i = 1'b1; step(); set_wen_i = 1'b0; clr_wen_i = 1'b0;
    chk("R3 both clears", status_o, st(2'b00, 1'b0));
  endtask

  task automatic t_deny();
    array_req(9'h000, 9'h003);
    chk("R4 no wen deny", deny_o, 1);
    chk("R10 no wen busy", busy_o, 0);
    pulse_set();
    wp_i = 1'b0;
    array_req(9'h000, 9'h003);
    chk("R4 wp low deny", deny_o, 1);
    chk("R10 wen kept", status_o, st(2'b00, 1'b1));
    chk("R10 busy not started", busy_o, 0);
    wp_i = 1'b1;
    step();
    chk("R7 deny one cycle", deny_o, 0);
    clr_wen_i = 1'b1; step(); clr_wen_i = 1'b0;
  endtask

  task automatic t_status_write();
    pulse_set();
    sr_data_i = 8'hF7; sr_wr_i = 1'b1; step(); sr_wr_i = 1'b0;
    chk("R7 grant", grant_o, 1);
    chk("R7 busy rises", busy_o, 1);
    chk("R9 busy status", status_o, 8'hFF);
    set_wen_i = 1'b1; step(); set_wen_i = 1'b0;
    chk("R7 grant one cycle", grant_o, 0);
    array_req(9'h000, 9'h000);
    chk("R9 busy deny", deny_o, 1);
    for (int i = 3; i < BUSY; i++) step();
    chk("R7 busy last cycle", busy_o, 1);
    step();
    chk("R8 busy falls", busy_o, 0);
    chk("R8 wen clears R6 bp", status_o, st(2'b01, 1'b0));
  endtask

  task automatic t_levels();
    // level 01 set by previous task
    pulse_set(); array_req(9'h17C, 9'h17F);
    chk("R5 lvl1 below", grant_o, 1); wait_idle();
    pulse_set(); array_req(9'h180, 9'h180);
    chk("R5 lvl1 base", deny_o, 1);
    array_req(9'h183, 9'h000);
    chk("R5 reversed order", deny_o, 1);
    clr_wen_i = 1'b1; step(); clr_wen_i = 1'b0;
    load_bp(2'b10);
    chk("R6 level2", status_o, st(2'b10, 1'b0));
    pulse_set(); array_req(9'h0FF, 9'h0FC);
    chk("R5 lvl2 below", grant_o, 1); wait_idle();
    pulse_set(); array_req(9'h100, 9'h101);
    chk("R5 lvl2 base", deny_o, 1);
    clr_wen_i = 1'b1; step(); clr_wen_i = 1'b0;
    load_bp(2'b11);
    pulse_set(); array_req(9'h000, 9'h000);
    chk("R5 lvl3 all", deny_o, 1);
    clr_wen_i = 1'b1; step(); clr_wen_i = 1'b0;
    load_bp(2'b00);
    pulse_set(); array_req(9'h1FC, 9'h1FF);
    chk("R5 lvl0 top", grant_o, 1); wait_idle();
    chk("R8 after array", status_o, st(2'b00, 1'b0));
  endtask

  task automatic t_priority();
    set_wen_i = 1'b1; prog_first_i = '0; prog_last_i = '0; prog_req_i = 1'b1; step();
    set_wen_i = 1'b0; prog_req_i = 1'b0;
    chk("R11 set ignored with req", status_o, st(2'b00, 1'b0));
    pulse_set();
    sr_data_i = 8'h0C; sr_wr_i = 1'b1; prog_req_i = 1'b1; step();
    sr_wr_i = 1'b0; prog_req_i = 1'b0;
    chk("R11 array wins grant", grant_o, 1);
    wait_idle();
    chk("R11 bp untouched", status_o, st(2'b00, 1'b0));
  endtask

  task automatic t_retain();
    load_bp(2'b11);
    pulse_set();
    rst_ni = 1'b0; step(); step(); rst_ni = 1'b1; step();
    chk("R2 bp retained wen cleared", status_o, st(2'b11, 1'b0));
    load_bp(2'b00);
    chk("R2 reload", status_o, st(2'b00, 1'b0));
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk_i);
    errors++;
    $display("FAIL R7 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step(); rst_ni = 1'b1; step();
    t_reset();
    t_latch();
    t_deny();
    t_status_write();
    t_levels();
    t_priority();
    t_retain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule